// File: doc/BRIEF.md
# Dual-Playfield Colour Mixer

This block sits at the end of a video pixel pipeline. Each clock it can take one 8-bit colour index from a background playfield and one from a foreground playfield. It looks up each index in that playfield's own 256-entry colour table and merges the two colours into one 12-bit RGB pixel. The foreground table holds a 4-bit opacity value in every entry. The background table holds colour only, because its opacity is never consulted.

Three merge styles are available. The first is an opacity blend with four foreground weights (0, 1/3, 2/3, 1), chosen by rounding the foreground opacity. The second is a per-channel additive mix that wraps modulo 16. The third is the same additive mix clamped at 15. A host loads the tables and the style register through plain write strobes. Table writes may land in the same cycle as display reads without disturbing them.

Top module: `pf_color_mixer`

## Requirements
- R1: While `rst_n` is low, and after its release, `rgb_valid_o` is 0, `rgb_o` is 0 and the merge style is opacity blend until the first style write.
- R2: `rgb_valid_o` is high exactly two rising edges after the edge that sampled `pix_valid_i` high. A pixel that is sampled at edge E0 is therefore shown after edge E1.
- R3: Whenever `rgb_valid_o` is low, `rgb_o` is 12'h000.
- R4: A table write with `pal_sel_i`=0 stores `pal_data_i[11:0]` at `pal_addr_i` in the background table. With `pal_sel_i`=1 it stores all 16 bits in the foreground table. A write to one table never changes the other table.
- R5: Entry layout is [15:12] opacity, [11:8] red, [7:4] green, [3:0] blue. In blend style the level L is 0 for opacity 0–2, 1 for 3–7, 2 for 8–12 and 3 for 13–15. Each channel is floor((L·F + (3−L)·B)/3), where F is the foreground channel and B is the background channel.
- R6: In wrapping additive style each channel is (F + B) mod 16.
- R7: In saturating additive style each channel is min(F + B, 15).
- R8: The style code is 0 for blend, 1 for wrapping add, 2 for saturating add and 3 for blend. It is loaded from `mode_i` when `mode_we_i` is high. A pixel sampled at the same edge as the write uses the old style, and later pixels use the new one.
- R9: When a table write and a display read of the same table and address share an edge, the read returns the old entry. A read at the next edge returns the new entry.
- R10: The opacity bits [15:12] of a background-table write have no effect on any output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Index pair present this cycle |
| bg_idx_i | input | 8 | Background playfield colour index |
| fg_idx_i | input | 8 | Foreground playfield colour index |
| pal_we_i | input | 1 | Colour table write strobe |
| pal_sel_i | input | 1 | Table select: 0 background, 1 foreground |
| pal_addr_i | input | 8 | Colour table write address |
| pal_data_i | input | 16 | Table entry: opacity, red, green, blue |
| mode_we_i | input | 1 | Merge style register write strobe |
| mode_i | input | 2 | Merge style code |
| rgb_o | output | 12 | Merged pixel, red in [11:8], blue in [3:0] |
| rgb_valid_o | output | 1 | `rgb_o` carries a merged pixel |

## Verification
The checker assumes that every colour index read while `pix_valid_i` is high points at an entry the host has already written. The table contents are never reset, so an unwritten entry would give channel bounds with no meaning. It also assumes that `pix_valid_i` is driven low throughout reset, because the latency property compares the output with the input two edges earlier. The stimulus loads every entry before presenting it, holds all strobes low during reset, and changes inputs only on falling clock edges.

// File: rtl/pf_mix_pkg.sv
package pf_mix_pkg;

    typedef enum logic [1:0] {
        MIX_BLEND     = 2'd0,
        MIX_ADD_WRAP  = 2'd1,
        MIX_ADD_SAT   = 2'd2,
        MIX_BLEND_ALT = 2'd3
    } mix_mode_e;

    localparam int unsigned NUM_CH = 3;
    localparam int unsigned LVL_W  = 2;

endpackage

// File: rtl/palette_ram.sv
module palette_ram #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // read-before-write: a same-edge read sees the previous entry
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_q <= mem_q[raddr_i];
    end

endmodule

// File: rtl/channel_mix.sv
module channel_mix
    import pf_mix_pkg::*;
#(
    parameter int unsigned CH_W = 4
) (
    input  logic [CH_W-1:0]  fg_i,
    input  logic [CH_W-1:0]  bg_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  mix_mode_e        mode_i,
    output logic [CH_W-1:0]  mix_o
);
    localparam int unsigned SUM_W  = CH_W + 1;
    localparam int unsigned WS_W   = CH_W + 2;
    localparam int unsigned PROD_W = WS_W + 6;

    logic [SUM_W-1:0]  sum;
    logic [WS_W-1:0]   wsum;
    logic [PROD_W-1:0] wx;
    logic [PROD_W-1:0] prod;
    logic [CH_W-1:0]   third;
    logic [CH_W-1:0]   blend;

    always_comb begin
        sum = {1'b0, fg_i} + {1'b0, bg_i};

        unique case (lvl_i)
            2'd1:    wsum = {2'b00, fg_i} + ({2'b00, bg_i} << 1);
            2'd2:    wsum = ({2'b00, fg_i} << 1) + {2'b00, bg_i};
            default: wsum = '0;
        endcase

        // x/3 as (x*43)>>7, exact for x < 128
        wx    = {6'b0, wsum};
        prod  = (wx << 5) + (wx << 3) + (wx << 1) + wx;
        third = prod[7 +: CH_W];

        unique case (lvl_i)
            2'd0:    blend = bg_i;
            2'd3:    blend = fg_i;
            default: blend = third;
        endcase

        unique case (mode_i)
            MIX_ADD_WRAP: mix_o = sum[CH_W-1:0];
            MIX_ADD_SAT:  mix_o = sum[CH_W] ? {CH_W{1'b1}} : sum[CH_W-1:0];
            default:      mix_o = blend;
        endcase
    end

endmodule

// File: rtl/blend_unit.sv
module blend_unit
    import pf_mix_pkg::*;
#(
    parameter int unsigned CH_W = 4
) (
    input  logic [4*CH_W-1:0]      fg_argb_i,
    input  logic [NUM_CH*CH_W-1:0] bg_rgb_i,
    input  mix_mode_e              mode_i,
    output logic [NUM_CH*CH_W-1:0] rgb_o
);
    localparam int unsigned ALPHA_MAX = (1 << CH_W) - 1;
    localparam int unsigned TH1 = (ALPHA_MAX + 2) / 5;
    localparam int unsigned TH2 = (ALPHA_MAX * 7 + 14) / 15 + 1;
    localparam int unsigned TH3 = (ALPHA_MAX * 13 + 14) / 15;

    logic [CH_W-1:0]  alpha;
    logic [LVL_W-1:0] lvl;

    // opacity rounded to the nearest of four levels
    always_comb begin
        alpha = fg_argb_i[4*CH_W-1 -: CH_W];
        if (32'(alpha) >= TH3)      lvl = 2'd3;
        else if (32'(alpha) >= TH2) lvl = 2'd2;
        else if (32'(alpha) >= TH1) lvl = 2'd1;
        else                        lvl = 2'd0;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        channel_mix #(.CH_W(CH_W)) i_channel_mix (
            .fg_i  (fg_argb_i[ch*CH_W +: CH_W]),
            .bg_i  (bg_rgb_i[ch*CH_W +: CH_W]),
            .lvl_i (lvl),
            .mode_i(mode_i),
            .mix_o (rgb_o[ch*CH_W +: CH_W])
        );
    end

endmodule

// File: rtl/pf_color_mixer.sv
module pf_color_mixer
    import pf_mix_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CH_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid_i,
    input  logic [IDX_W-1:0]       bg_idx_i,
    input  logic [IDX_W-1:0]       fg_idx_i,
    input  logic                   pal_we_i,
    input  logic                   pal_sel_i,
    input  logic [IDX_W-1:0]       pal_addr_i,
    input  logic [4*CH_W-1:0]      pal_data_i,
    input  logic                   mode_we_i,
    input  logic [1:0]             mode_i,
    output logic [NUM_CH*CH_W-1:0] rgb_o,
    output logic                   rgb_valid_o
);
    localparam int unsigned RGB_W  = NUM_CH * CH_W;
    localparam int unsigned ARGB_W = 4 * CH_W;

    typedef struct packed {
        mix_mode_e        mode;
        logic             s1_vld;
        mix_mode_e        s1_mode;
        logic             out_vld;
        logic [RGB_W-1:0] out_rgb;
    } mix_state_t;

    localparam mix_state_t STATE_RST = '{
        mode:    MIX_BLEND,
        s1_vld:  1'b0,
        s1_mode: MIX_BLEND,
        out_vld: 1'b0,
        out_rgb: '0
    };

    mix_state_t        st_d, st_q;
    logic [RGB_W-1:0]  bg_rd;
    logic [ARGB_W-1:0] fg_rd;
    logic [RGB_W-1:0]  mixed;
    mix_mode_e         s1_mode_w;

    palette_ram #(.IDX_W(IDX_W), .DATA_W(RGB_W)) i_bg_pal (
        .clk    (clk),
        .we_i   (pal_we_i & ~pal_sel_i),
        .waddr_i(pal_addr_i),
        .wdata_i(pal_data_i[RGB_W-1:0]),
        .raddr_i(bg_idx_i),
        .rdata_q(bg_rd)
    );

    palette_ram #(.IDX_W(IDX_W), .DATA_W(ARGB_W)) i_fg_pal (
        .clk    (clk),
        .we_i   (pal_we_i & pal_sel_i),
        .waddr_i(pal_addr_i),
        .wdata_i(pal_data_i),
        .raddr_i(fg_idx_i),
        .rdata_q(fg_rd)
    );

    assign s1_mode_w = st_q.s1_mode;

    blend_unit #(.CH_W(CH_W)) i_blend_unit (
        .fg_argb_i(fg_rd),
        .bg_rgb_i (bg_rd),
        .mode_i   (s1_mode_w),
        .rgb_o    (mixed)
    );

    always_comb begin
        st_d = st_q;
        if (mode_we_i) begin
            st_d.mode = mix_mode_e'(mode_i);
        end
        st_d.s1_vld  = pix_valid_i;
        st_d.s1_mode = st_q.mode;
        st_d.out_vld = st_q.s1_vld;
        st_d.out_rgb = st_q.s1_vld ? mixed : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb_o       = st_q.out_rgb;
    assign rgb_valid_o = st_q.out_vld;

endmodule

// File: rtl/pf_color_mixer_chk.sv
module pf_color_mixer_chk
    import pf_mix_pkg::*;
#(
    parameter int unsigned CH_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pix_valid_i,
    input logic                   rgb_valid_o,
    input logic [NUM_CH*CH_W-1:0] rgb_o,
    input logic [4*CH_W-1:0]      s1_fg,
    input logic [NUM_CH*CH_W-1:0] s1_bg,
    input logic [1:0]             s1_mode
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    function automatic logic all_between(logic [NUM_CH*CH_W-1:0] o, f, b);
        logic ok = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (o[c*CH_W +: CH_W] < ((f[c*CH_W +: CH_W] < b[c*CH_W +: CH_W]) ?
                                     f[c*CH_W +: CH_W] : b[c*CH_W +: CH_W])) ok = 1'b0;
            if (o[c*CH_W +: CH_W] > ((f[c*CH_W +: CH_W] > b[c*CH_W +: CH_W]) ?
                                     f[c*CH_W +: CH_W] : b[c*CH_W +: CH_W])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic all_at_least(logic [NUM_CH*CH_W-1:0] o, f, b);
        logic ok = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (o[c*CH_W +: CH_W] < f[c*CH_W +: CH_W]) ok = 1'b0;
            if (o[c*CH_W +: CH_W] < b[c*CH_W +: CH_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rgb_valid_o && rgb_o == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (rgb_valid_o == $past(pix_valid_i, 2)));

    // R3
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_valid_o |-> (rgb_o == '0));

    // R5
    blend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_valid_o && ($past(s1_mode) == MIX_BLEND || $past(s1_mode) == MIX_BLEND_ALT))
        |-> all_between(rgb_o, $past(s1_fg[NUM_CH*CH_W-1:0]), $past(s1_bg)));

    // R5
    opaque_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_valid_o && $past(s1_mode) == MIX_BLEND && $past(s1_fg[4*CH_W-1 -: CH_W]) == '1)
        |-> (rgb_o == $past(s1_fg[NUM_CH*CH_W-1:0])));

    // R7
    sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_valid_o && $past(s1_mode) == MIX_ADD_SAT)
        |-> all_at_least(rgb_o, $past(s1_fg[NUM_CH*CH_W-1:0]), $past(s1_bg)));

endmodule

bind pf_color_mixer pf_color_mixer_chk #(.CH_W(CH_W)) i_pf_color_mixer_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid_i(pix_valid_i),
    .rgb_valid_o(rgb_valid_o),
    .rgb_o      (rgb_o),
    .s1_fg      (fg_rd),
    .s1_bg      (bg_rd),
    .s1_mode    (s1_mode_w)
);

// File: tb/test_pf_color_mixer.sv
module test_pf_color_mixer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  bg_idx_i = '0;
    logic [7:0]  fg_idx_i = '0;
    logic        pal_we_i = 1'b0;
    logic        pal_sel_i = 1'b0;
    logic [7:0]  pal_addr_i = '0;
    logic [15:0] pal_data_i = '0;
    logic        mode_we_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [11:0] rgb_o;
    logic        rgb_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_color_mixer i_pf_color_mixer (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
        .bg_idx_i(bg_idx_i), .fg_idx_i(fg_idx_i),
        .pal_we_i(pal_we_i), .pal_sel_i(pal_sel_i), .pal_addr_i(pal_addr_i),
        .pal_data_i(pal_data_i), .mode_we_i(mode_we_i), .mode_i(mode_i),
        .rgb_o(rgb_o), .rgb_valid_o(rgb_valid_o)
    );

    // reference model taken from the requirement text
    function automatic logic [11:0] model(logic [15:0] fg, logic [15:0] bg, int m);
        logic [11:0] r;
        int lvl = (int'(fg[15:12]) * 3 + 7) / 15;
        for (int c = 0; c < 3; c++) begin
            int f = int'(fg[c*4 +: 4]);
            int b = int'(bg[c*4 +: 4]);
            int v;
            if (m == 1)      v = (f + b) % 16;
            else if (m == 2) v = (f + b > 15) ? 15 : f + b;
            else             v = (lvl * f + (3 - lvl) * b) / 3;
            r[c*4 +: 4] = 4'(v);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pal_write(logic sel, logic [7:0] addr, logic [15:0] data);
        @(negedge clk);
        pal_we_i = 1'b1; pal_sel_i = sel; pal_addr_i = addr; pal_data_i = data;
        @(negedge clk);
        pal_we_i = 1'b0;
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_we_i = 1'b1; mode_i = m;
        @(negedge clk);
        mode_we_i = 1'b0;
    endtask

    task automatic pixel(logic [7:0] bi, logic [7:0] fi, output logic [11:0] rgb, output logic vld);
        @(negedge clk);
        pix_valid_i = 1'b1; bg_idx_i = bi; fg_idx_i = fi;
        @(negedge clk);
        pix_valid_i = 1'b0;
        @(negedge clk);
        rgb = rgb_o; vld = rgb_valid_o;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid in reset", 32'(rgb_valid_o), 0);
        chk("R1 rgb in reset", 32'(rgb_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", 32'(rgb_valid_o), 0);
        chk("R1 rgb after reset", 32'(rgb_o), 0);
    endtask

    task automatic t_default_blend();
        logic [11:0] r; logic v;
        pal_write(1'b0, 8'h10, 16'hF3C5);
        pal_write(1'b1, 8'h20, 16'h0ABC);
        pixel(8'h10, 8'h20, r, v);
        chk("R1 default style is blend", 32'(r), 32'(model(16'h0ABC, 16'hF3C5, 0)));
        chk("R2 valid after pixel", 32'(v), 1);
        pal_write(1'b1, 8'h21, 16'hFABC);
        pixel(8'h10, 8'h21, r, v);
        chk("R5 level 3 gives foreground", 32'(r), 32'hABC);
    endtask

    task automatic t_blend_levels();
        logic [11:0] r; logic v;
        logic [3:0] alphas [6] = '{4'd2, 4'd3, 4'd7, 4'd8, 4'd12, 4'd13};
        pal_write(1'b0, 8'h11, 16'h06A3);
        for (int i = 0; i < 6; i++) begin
            pal_write(1'b1, 8'(8'h30 + i), {alphas[i], 12'h9F0});
            pixel(8'h11, 8'(8'h30 + i), r, v);
            chk($sformatf("R5 blend alpha %0d", alphas[i]), 32'(r),
                32'(model({alphas[i], 12'h9F0}, 16'h06A3, 0)));
        end
    endtask

    task automatic t_bg_alpha_ignored();
        logic [11:0] r0, r1; logic v;
        pal_write(1'b1, 8'h40, 16'h85E7);
        pal_write(1'b0, 8'h12, 16'h0C18);
        pal_write(1'b0, 8'h13, 16'hFC18);
        pixel(8'h12, 8'h40, r0, v);
        pixel(8'h13, 8'h40, r1, v);
        chk("R10 bg opacity 0", 32'(r0), 32'(model(16'h85E7, 16'h0C18, 0)));
        chk("R10 bg opacity 15", 32'(r1), 32'(r0));
    endtask

    task automatic t_additive();
        logic [11:0] r; logic v;
        pal_write(1'b0, 8'h14, 16'h09F2);
        pal_write(1'b1, 8'h41, 16'h7A13);
        set_mode(2'd1);
        pixel(8'h14, 8'h41, r, v);
        chk("R6 wrapping add", 32'(r), 32'h305);
        set_mode(2'd2);
        pixel(8'h14, 8'h41, r, v);
        chk("R7 saturating add", 32'(r), 32'hFF5);
        set_mode(2'd3);
        pixel(8'h14, 8'h41, r, v);
        chk("R8 code 3 blends", 32'(r), 32'(model(16'h7A13, 16'h09F2, 0)));
        set_mode(2'd0);
    endtask

    task automatic t_mode_timing();
        logic [11:0] r1, r2;
        @(negedge clk);
        mode_we_i = 1'b1; mode_i = 2'd2;
        pix_valid_i = 1'b1; bg_idx_i = 8'h14; fg_idx_i = 8'h41;
        @(negedge clk);
        mode_we_i = 1'b0;
        @(negedge clk);
        pix_valid_i = 1'b0;
        r1 = rgb_o;
        @(negedge clk);
        r2 = rgb_o;
        chk("R8 same-edge pixel keeps old style", 32'(r1), 32'(model(16'h7A13, 16'h09F2, 0)));
        chk("R8 later pixel uses new style", 32'(r2), 32'hFF5);
        set_mode(2'd0);
    endtask

    task automatic t_collision();
        logic [11:0] r1, r2;
        pal_write(1'b0, 8'h15, 16'h0000);
        pal_write(1'b1, 8'h50, 16'hF123);
        @(negedge clk);
        pal_we_i = 1'b1; pal_sel_i = 1'b1; pal_addr_i = 8'h50; pal_data_i = 16'hF9AB;
        pix_valid_i = 1'b1; bg_idx_i = 8'h15; fg_idx_i = 8'h50;
        @(negedge clk);
        pal_we_i = 1'b0;
        @(negedge clk);
        pix_valid_i = 1'b0;
        r1 = rgb_o;
        @(negedge clk);
        r2 = rgb_o;
        chk("R9 colliding read sees old entry", 32'(r1), 32'h123);
        chk("R9 next read sees new entry", 32'(r2), 32'h9AB);
    endtask

    task automatic t_isolation();
        logic [11:0] r; logic v;
        pal_write(1'b0, 8'h60, 16'h0111);
        pal_write(1'b1, 8'h60, 16'hF222);
        pixel(8'h60, 8'h60, r, v);
        chk("R4 foreground entry stored", 32'(r), 32'h222);
        pal_write(1'b1, 8'h60, 16'h0222);
        pixel(8'h60, 8'h60, r, v);
        chk("R4 background entry intact", 32'(r), 32'h111);
    endtask

    task automatic t_stream();
        logic pat [10] = '{1, 0, 1, 1, 0, 0, 1, 0, 0, 0};
        // foreground fully opaque so valid pixels are never zero
        pal_write(1'b1, 8'h70, 16'hF5A5);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk($sformatf("R2 valid slot %0d", k), 32'(rgb_valid_o), 32'(pat[k-2]));
                if (pat[k-2]) chk("R2 data in slot", 32'(rgb_o), 32'h5A5);
                else          chk("R3 blank slot zero", 32'(rgb_o), 0);
            end
            pix_valid_i = pat[k]; bg_idx_i = 8'h60; fg_idx_i = 8'h70;
        end
        pix_valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_default_blend();
        t_blend_levels();
        t_bg_alpha_ignored();
        t_additive();
        t_mode_timing();
        t_collision();
        t_isolation();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule